// File: doc/BRIEF.md
# Raster line-match interrupt controller

This block watches a running raster position and records an event whenever the position reaches one of several programmed points. Each of four sources holds its own target row and column. When the incoming column and row counters both equal a source's target, that source's pending bit is latched and stays latched until software acknowledges it. The pending bits can be read at one word address. They are acknowledged by writing ones to a different word address, so reading never disturbs them.

A per-source enable mask decides which pending bits may reach the single interrupt line. That line is taken from a flop, so it carries no combinational glitches. The raster counters are produced outside this block. The register bus is a plain single-cycle write port with a combinational read port.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset, all four target registers, the mask (word 6) and the pending bits (word 4) read as zero, and `irq_o` is low.
- R2: Target registers sit at word addresses 0 to 3, one per source. In each, bits 28:16 hold the target row and bits 12:0 hold the target column. All other bits are ignored on write and read back as zero.
- R3: Pending bit i (word 4, bit i) becomes 1 at the clock edge that samples `pix_x` and `pix_y` equal to both coordinates of target i. A match on the column only, or on the row only, sets nothing.
- R4: A pending bit that is set stays set through later cycles, with or without further matches, until it is acknowledged.
- R5: Writing word 5 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. Word 5 reads as zero.
- R6: Writes to word 4 have no effect on the pending bits.
- R7: If a match for source i and an acknowledge of bit i land on the same clock edge, bit i ends up set.
- R8: Mask bit i (word 6, bits 3:0; 1 = enabled) lets pending bit i reach `irq_o`. `irq_o` equals the OR of pending AND mask as held in the registers one clock earlier.
- R9: Acknowledging a stale pending bit and then enabling its mask bit on the next write gives no pulse on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | 13 | Current raster column |
| pix_y | input | 13 | Current raster row |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The raster is swept over a small frame in which the targets share rows and columns with each other. This shows whether a source fires on a full match only, or wrongly on a row-only or column-only match. Revisiting targets that are already pending separates sticky behaviour from a bit that merely follows the current match. Acknowledges with mixed bit patterns, including one timed to land on a live match, tell per-bit clearing apart from whole-register clearing and show which side wins a collision. A stale-bit acknowledge followed by an unmask, and then a fresh match, checks both that no false pulse appears and that a real pulse arrives with one cycle of latency.

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl #(
  parameter int NSRC  = 4,
  parameter int CW    = 13,
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int Y_LSB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int A_STAT = NSRC;
  localparam int A_CLR  = NSRC + 1;
  localparam int A_MASK = NSRC + 2;

  logic [CW-1:0]   tgt_x [NSRC];
  logic [CW-1:0]   tgt_y [NSRC];
  logic [NSRC-1:0] hit_v, clr_v, pend, mask;

  assign clr_v = (bus_wr && bus_addr == AW'(A_CLR)) ? bus_wdata[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        tgt_x[i] <= '0;
        tgt_y[i] <= '0;
      end else if (bus_wr && bus_addr == AW'(i)) begin
        tgt_x[i] <= bus_wdata[CW-1:0];
        tgt_y[i] <= bus_wdata[Y_LSB +: CW];
      end
    assign hit_v[i] = (pix_x == tgt_x[i]) && (pix_y == tgt_y[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      irq_o <= 1'b0;
    end else begin
      pend  <= (pend & ~clr_v) | hit_v;
      irq_o <= |(pend & mask);
      if (bus_wr && bus_addr == AW'(A_MASK)) mask <= bus_wdata[NSRC-1:0];
    end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (bus_addr == AW'(i)) begin
        bus_rdata[CW-1:0]       = tgt_x[i];
        bus_rdata[Y_LSB +: CW]  = tgt_y[i];
      end
    if (bus_addr == AW'(A_STAT)) bus_rdata[NSRC-1:0] = pend;
    if (bus_addr == AW'(A_MASK)) bus_rdata[NSRC-1:0] = mask;
  end

  // R3 R7
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(hit_v)) == $past(hit_v)));
  // R4 R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr_v) & ~pend) == '0));
  // R6
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(hit_v)) == '0));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(pend) & $past(mask))));
endmodule

// File: tb/sim_line_irq_ctrl.sv
module sim_line_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [12:0] pix_x = 0, pix_y = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq_o;
  int checks = 0, fails = 0;

  line_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  int m_x[4], m_y[4];
  bit [3:0] m_pend, m_mask;
  bit m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_x[i]) begin m_x[i] = 0; m_y[i] = 0; end
      m_pend = 0; m_mask = 0; m_irq = 0;
    end else begin
      bit [3:0] nxt;
      m_irq = |(m_pend & m_mask);
      nxt = m_pend;
      if (bus_wr && bus_addr == 5) nxt = nxt & ~bus_wdata[3:0];
      for (int i = 0; i < 4; i++)
        if (int'(pix_x) == m_x[i] && int'(pix_y) == m_y[i]) nxt[i] = 1;
      if (bus_wr && bus_addr < 4) begin
        m_x[bus_addr] = int'(bus_wdata[12:0]);
        m_y[bus_addr] = int'(bus_wdata[28:16]);
      end
      if (bus_wr && bus_addr == 6) m_mask = bus_wdata[3:0];
      m_pend = nxt;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r = 0;
    if (a < 4) begin r[12:0] = 13'(m_x[a]); r[28:16] = 13'(m_y[a]); end
    else if (a == 4) r[3:0] = m_pend;
    else if (a == 6) r[3:0] = m_mask;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    chk({tag, " rdata"}, bus_rdata, m_read(bus_addr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(tag);
    bus_wr = 0; bus_addr = 4;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic sweep(input int rows, input int cols, input string tag);
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < cols; x++) begin
        pix_x = 13'(x); pix_y = 13'(y);
        cyc(tag);
      end
    pix_x = 13'h1fff; pix_y = 13'h1fff;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pix_x = 13'h1fff; pix_y = 13'h1fff;
    #12;
    for (int a = 0; a < 7; a++) rd(3'(a), 0, "R1 reset reg");
    chk("R1 reset irq", {31'b0, irq_o}, 0);
    @(negedge clk); rst_n = 1;
    cyc("R1 idle");

    // R2 target layout, stray bits dropped
    wr(0, 32'hE002_E003, "R2 wr0");
    wr(1, 32'h0002_0007, "R2 wr1");
    wr(2, 32'h0005_0003, "R2 wr2");
    wr(3, 32'h0006_0000, "R2 wr3");
    rd(0, 32'h0002_0003, "R2 readback0");
    rd(2, 32'h0005_0003, "R2 readback2");

    // R3 sweep: shared rows/cols, partial matches must not fire
    sweep(3, 5, "R3 sweep_a");
    rd(4, 32'h1, "R3 only src0");
    sweep(8, 10, "R3 sweep_b");
    rd(4, 32'hF, "R3 all fired");
    // R4 sticky
    repeat (5) cyc("R4 hold");
    rd(4, 32'hF, "R4 still set");

    // R5 selective clear, clear word reads 0
    wr(5, 32'h5, "R5 clr");
    rd(4, 32'hA, "R5 partial");
    rd(5, 32'h0, "R5 readzero");
    // R6 status word ignores writes
    wr(4, 32'hF, "R6 wr stat");
    rd(4, 32'hA, "R6 unchanged");
    wr(4, 32'h0, "R6 wr stat0");
    rd(4, 32'hA, "R6 unchanged0");

    // R7 collision: match src2 and clear bit2 in one cycle
    wr(5, 32'hF, "R7 clr all");
    pix_x = 3; pix_y = 5;
    wr(5, 32'h4, "R7 collide");
    pix_x = 13'h1fff; pix_y = 13'h1fff;
    rd(4, 32'h4, "R7 set wins");

    // R8 mask gating and latency
    wr(6, 32'h1, "R8 mask0");
    cyc("R8 masked");
    chk("R8 masked low", {31'b0, irq_o}, 0);
    wr(6, 32'h4, "R8 mask2");
    chk("R8 not yet", {31'b0, irq_o}, 0);
    cyc("R8 rise");
    chk("R8 irq high", {31'b0, irq_o}, 1);
    wr(6, 32'h0, "R8 unmask off");
    cyc("R8 fall");
    chk("R8 irq low", {31'b0, irq_o}, 0);

    // R9 stale bit: clear then unmask
    sweep(3, 5, "R9 make stale");
    rd(4, 32'h5, "R9 stale present");
    wr(5, 32'h1, "R9 clear");
    chk("R9 no pulse a", {31'b0, irq_o}, 0);
    wr(6, 32'h1, "R9 unmask");
    chk("R9 no pulse b", {31'b0, irq_o}, 0);
    for (int k = 0; k < 4; k++) begin
      cyc("R9 quiet");
      chk("R9 no pulse", {31'b0, irq_o}, 0);
    end
    pix_x = 3; pix_y = 2; cyc("R9 fresh");
    pix_x = 13'h1fff; pix_y = 13'h1fff;
    cyc("R9 fresh irq");
    chk("R9 real pulse", {31'b0, irq_o}, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule